// File: doc/BRIEF.md
# One-Wire Reset/Presence Sequencer

This block runs the reset and presence-detect cycle of an open-drain single-wire bus. A one-cycle start strobe makes it pull the line low for a reset-low interval and then release it for a reset-high interval. While the line is released it samples the bus twice. The first sample comes shortly after release. A line that is still low at that point means the bus is shorted. The second sample comes later, inside the window where attached devices answer. A low line at that point means a device is present.

All interval lengths are parameters counted in clock cycles. There is one set for standard speed and one for overdrive. The speed, presence-masking and active-pullup settings are captured when a cycle starts and stay in force until it ends. The block reports a busy flag for the whole cycle and two result flags, presence and short. Both result flags stay valid after the cycle ends, until the next cycle starts.

Top module: `owire_rst_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, every output is 0.
- R2: A start strobe sampled while idle makes `bus_low_o` go high in the very next cycle. With `speed_i`=0 it stays high for exactly LOW_STD (480) cycles; with `speed_i`=1 it stays high for exactly LOW_OD (48) cycles.
- R3: `busy_o` rises in the same cycle as `bus_low_o`. It stays high for exactly low+high cycles: 960 at standard speed, 96 in overdrive.
- R4: The line is sampled SI cycles after release (8 at standard speed). A low line there sets `short_o`, and the flag first shows in cycle index low+SI+1, counted from the first busy cycle as index 0 (489 at standard speed).
- R5: The line is sampled MSP cycles after release (70 at standard speed, 8 in overdrive). A low line there sets `presence_o`, and the flag first shows in cycle index low+MSP+1 (551 at standard speed, 57 in overdrive). A high line at both sample points leaves both flags at 0.
- R6: Both flags read 0 in the first busy cycle of every new reset cycle. Both flags keep their value after `busy_o` falls, until the next start.
- R7: `speed_i`, `mask_i` and `apu_i` are captured at the start strobe. Changing them during a cycle has no effect on that cycle.
- R8: With `mask_i`=1 at start, `presence_o` stays 0 even when a device answers.
- R9: With `apu_i`=1 at start, `pullup_o` is high for exactly PU_CYC (6) cycles, starting at the first released cycle (index low). `pullup_o` is never high together with `bus_low_o`, and stays 0 when `apu_i`=0.
- R10: A start strobe that arrives while `busy_o` is high is ignored. The cycle in progress keeps its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle strobe that requests a reset cycle |
| speed_i | input | 1 | 1 selects the overdrive interval set |
| mask_i | input | 1 | 1 keeps the presence flag from being set |
| apu_i | input | 1 | 1 enables the strong pullup pulse after release |
| line_i | input | 1 | Sampled bus level |
| bus_low_o | output | 1 | Open-drain enable: 1 pulls the bus low, 0 releases it |
| pullup_o | output | 1 | Strong pullup enable |
| busy_o | output | 1 | A reset cycle is in progress |
| presence_o | output | 1 | A device answered in the last cycle |
| short_o | output | 1 | The bus was found low just after release |

## Verification
The hardest behaviour to reach is a second start strobe that lands in the middle of a cycle, arriving together with a changed speed setting. If the block wrongly accepted either one, the only trace would be a different cycle length. The bench raises the strobe and flips the speed input at a fixed cycle index inside the low phase. It then counts the busy and low cycles from the original start and compares them with the standard-speed totals. A bus model inside the bench pulls the line low over a chosen window after release, or holds it low the whole time. This lets it place the two sample instants on either side of a device answer and record the exact cycle in which each flag first appears.

// File: rtl/owire_rst_pkg.sv
package owire_rst_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;
endpackage

// File: rtl/owire_rst_timer.sv
module owire_rst_timer
  import owire_rst_pkg::*;
#(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_i,
  input  logic [CW-1:0] low_len_i,
  input  logic [CW-1:0] high_len_i,
  output phase_e        phase_o,
  output logic [CW-1:0] cnt_o,
  output logic          bus_low_o,
  output logic          busy_o
);
  logic [CW-1:0] one_c;
  assign one_c = CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_o   <= PH_IDLE;
      cnt_o     <= '0;
      bus_low_o <= 1'b0;
      busy_o    <= 1'b0;
    end else begin
      unique case (phase_o)
        PH_IDLE: begin
          if (go_i) begin
            phase_o   <= PH_LOW;
            cnt_o     <= '0;
            bus_low_o <= 1'b1;
            busy_o    <= 1'b1;
          end
        end
        PH_LOW: begin
          if (cnt_o == low_len_i - one_c) begin
            phase_o   <= PH_HIGH;
            cnt_o     <= '0;
            bus_low_o <= 1'b0;
          end else begin
            cnt_o <= cnt_o + one_c;
          end
        end
        PH_HIGH: begin
          if (cnt_o == high_len_i - one_c) begin
            phase_o <= PH_IDLE;
            cnt_o   <= '0;
            busy_o  <= 1'b0;
          end else begin
            cnt_o <= cnt_o + one_c;
          end
        end
        default: begin
          phase_o   <= PH_IDLE;
          cnt_o     <= '0;
          bus_low_o <= 1'b0;
          busy_o    <= 1'b0;
        end
      endcase
    end
  end

  // R3: the low drive only ever happens inside a busy window
  assert_low_inside_busy_R3: assert property (@(posedge clk) disable iff (rst)
    bus_low_o |-> busy_o);

  // R2: the low drive starts only after an accepted launch
  assert_low_after_go_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_low_o) |-> $past(go_i));

  // R3: busy ends only from the released phase
  assert_busy_ends_high_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> $past(phase_o == PH_HIGH));
endmodule

// File: rtl/owire_rst_sampler.sv
module owire_rst_sampler
  import owire_rst_pkg::*;
#(
  parameter int CW     = 9,
  parameter int PU_CYC = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic          rel_i,
  input  phase_e        phase_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          line_i,
  input  logic [CW-1:0] si_i,
  input  logic [CW-1:0] msp_i,
  input  logic          mask_i,
  input  logic          apu_i,
  output logic          presence_o,
  output logic          short_o,
  output logic          pullup_o
);
  localparam logic [CW-1:0] PU_LAST = CW'(PU_CYC - 1);

  logic in_high;
  assign in_high = (phase_i == PH_HIGH);

  always_ff @(posedge clk) begin
    if (rst) begin
      presence_o <= 1'b0;
      short_o    <= 1'b0;
    end else if (clear_i) begin
      presence_o <= 1'b0;
      short_o    <= 1'b0;
    end else if (in_high) begin
      if (cnt_i == si_i) short_o <= ~line_i;
      if (cnt_i == msp_i && !mask_i) presence_o <= ~line_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      pullup_o <= 1'b0;
    end else if (rel_i) begin
      pullup_o <= apu_i;
    end else if (in_high && cnt_i == PU_LAST) begin
      pullup_o <= 1'b0;
    end else if (!in_high) begin
      pullup_o <= 1'b0;
    end
  end

  // R4: the short flag rises only from a sample in the released phase
  assert_short_from_release_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(short_o) |-> $past(in_high));

  // R5 / R8: the presence flag rises only from an unmasked released-phase sample
  assert_pres_unmasked_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(presence_o) |-> ($past(in_high) && !$past(mask_i)));

  // R9: the pullup pulse never overlaps the low phase
  assert_pullup_not_low_R9: assert property (@(posedge clk) disable iff (rst)
    pullup_o |-> (phase_i != PH_LOW));
endmodule

// File: rtl/owire_rst_seq.sv
module owire_rst_seq
  import owire_rst_pkg::*;
#(
  parameter int LOW_STD  = 480,
  parameter int HIGH_STD = 480,
  parameter int MSP_STD  = 70,
  parameter int SI_STD   = 8,
  parameter int LOW_OD   = 48,
  parameter int HIGH_OD  = 48,
  parameter int MSP_OD   = 8,
  parameter int SI_OD    = 2,
  parameter int PU_CYC   = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic speed_i,
  input  logic mask_i,
  input  logic apu_i,
  input  logic line_i,
  output logic bus_low_o,
  output logic pullup_o,
  output logic busy_o,
  output logic presence_o,
  output logic short_o
);
  localparam int MAX_A = (LOW_STD > HIGH_STD) ? LOW_STD : HIGH_STD;
  localparam int MAX_B = (LOW_OD > HIGH_OD) ? LOW_OD : HIGH_OD;
  localparam int MAX_L = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAX_L + 1);

  phase_e        phase;
  logic [CW-1:0] cnt;
  logic          speed_q, mask_q, apu_q;
  logic          launch, rel;
  logic [CW-1:0] t_low, t_high, t_si, t_msp;

  assign launch = start_i && (phase == PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      speed_q <= 1'b0;
      mask_q  <= 1'b0;
      apu_q   <= 1'b0;
    end else if (launch) begin
      speed_q <= speed_i;
      mask_q  <= mask_i;
      apu_q   <= apu_i;
    end
  end

  assign t_low  = speed_q ? CW'(LOW_OD)  : CW'(LOW_STD);
  assign t_high = speed_q ? CW'(HIGH_OD) : CW'(HIGH_STD);
  assign t_si   = speed_q ? CW'(SI_OD)   : CW'(SI_STD);
  assign t_msp  = speed_q ? CW'(MSP_OD)  : CW'(MSP_STD);
  assign rel    = (phase == PH_LOW) && (cnt == t_low - CW'(1));

  owire_rst_timer #(.CW(CW)) timer_i (
    .clk        (clk),
    .rst        (rst),
    .go_i       (launch),
    .low_len_i  (t_low),
    .high_len_i (t_high),
    .phase_o    (phase),
    .cnt_o      (cnt),
    .bus_low_o  (bus_low_o),
    .busy_o     (busy_o)
  );

  owire_rst_sampler #(.CW(CW), .PU_CYC(PU_CYC)) sampler_i (
    .clk        (clk),
    .rst        (rst),
    .clear_i    (launch),
    .rel_i      (rel),
    .phase_i    (phase),
    .cnt_i      (cnt),
    .line_i     (line_i),
    .si_i       (t_si),
    .msp_i      (t_msp),
    .mask_i     (mask_q),
    .apu_i      (apu_q),
    .presence_o (presence_o),
    .short_o    (short_o),
    .pullup_o   (pullup_o)
  );

  // R6: both result flags read clear in the first busy cycle
  assert_flags_clear_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (!presence_o && !short_o));

  // R9: strong pullup and low drive never overlap
  assert_pullup_excl_R9: assert property (@(posedge clk) disable iff (rst)
    pullup_o |-> !bus_low_o);

  // R10: a new low drive never follows a cycle that was already busy
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_low_o) |-> !$past(busy_o));
endmodule

// File: tb/owire_rst_seq_tb.sv
module owire_rst_seq_tb_top;
  localparam int LS = 480, HS = 480, MS = 70, SS = 8;
  localparam int LO = 48,  HO = 48,  MO = 8;
  localparam int PU = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, speed_i = 1'b0, mask_i = 1'b0, apu_i = 1'b0;
  logic line_i;
  logic bus_low_o, pullup_o, busy_o, presence_o, short_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // bus model
  logic dev_on = 1'b0, short_on = 1'b0;
  int   pw0 = 0, pw1 = 0;
  int   rel_cnt = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bus_low_o) rel_cnt <= 0;
    else rel_cnt <= rel_cnt + 1;
  end

  assign line_i = bus_low_o ? 1'b0 :
                  short_on  ? 1'b0 :
                  (dev_on && rel_cnt >= pw0 && rel_cnt < pw1) ? 1'b0 : 1'b1;

  owire_rst_seq dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .speed_i(speed_i),
    .mask_i(mask_i), .apu_i(apu_i), .line_i(line_i),
    .bus_low_o(bus_low_o), .pullup_o(pullup_o), .busy_o(busy_o),
    .presence_o(presence_o), .short_o(short_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // results of one measured cycle
  int busy_n, low_n, pu_n, pu_first, pres_first, short_first;
  int pres0, short0, low0, fin_pres, fin_short, overlap;

  task automatic run_cycle(input int restart_at);
    busy_n = 0; low_n = 0; pu_n = 0; overlap = 0;
    pu_first = -1; pres_first = -1; short_first = -1;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    pres0 = presence_o; short0 = short_o; low0 = bus_low_o;
    for (int i = 0; i < 5000; i++) begin
      if (!busy_o) break;
      busy_n++;
      if (bus_low_o) low_n++;
      if (pullup_o) begin
        pu_n++;
        if (pu_first < 0) pu_first = i;
        if (bus_low_o) overlap++;
      end
      if (presence_o && pres_first < 0) pres_first = i;
      if (short_o && short_first < 0) short_first = i;
      if (i == restart_at) begin
        start_i = 1'b1; speed_i = ~speed_i;
        mask_i = ~mask_i; apu_i = ~apu_i;
      end else if (i == restart_at + 1) begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    fin_pres = presence_o; fin_short = short_o;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!bus_low_o && !busy_o && !pullup_o && !presence_o && !short_o,
        "R1 outputs during reset", int'({bus_low_o, busy_o, pullup_o, presence_o, short_o}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_low_o && !busy_o && !pullup_o && !presence_o && !short_o,
        "R1 outputs after reset", int'({bus_low_o, busy_o, pullup_o, presence_o, short_o}), 0);
  endtask

  task automatic t_std_present;
    speed_i = 0; mask_i = 0; apu_i = 0;
    dev_on = 1; short_on = 0; pw0 = 15; pw1 = 240;
    run_cycle(-10);
    chk(low0 == 1, "R2 low in first cycle", low0, 1);
    chk(low_n == LS, "R2 std low length", low_n, LS);
    chk(busy_n == LS + HS, "R3 std busy length", busy_n, LS + HS);
    chk(pres_first == LS + MS + 1, "R5 std presence timing", pres_first, LS + MS + 1);
    chk(fin_short == 0 && short_first < 0, "R4 no short on healthy bus", fin_short, 0);
    chk(pu_n == 0, "R9 no pullup when disabled", pu_n, 0);
    chk(fin_pres == 1, "R6 presence held after cycle", fin_pres, 1);
  endtask

  task automatic t_std_absent;
    dev_on = 0; short_on = 0;
    run_cycle(-10);
    chk(pres0 == 0, "R6 presence cleared at start", pres0, 0);
    chk(fin_pres == 0 && pres_first < 0, "R5 no device no presence", fin_pres, 0);
    chk(fin_short == 0, "R5 no device no short", fin_short, 0);
  endtask

  task automatic t_short;
    dev_on = 0; short_on = 1;
    run_cycle(-10);
    chk(short_first == LS + SS + 1, "R4 short timing", short_first, LS + SS + 1);
    chk(pres_first == LS + MS + 1, "R5 presence on held-low line", pres_first, LS + MS + 1);
    chk(fin_short == 1, "R6 short held after cycle", fin_short, 1);
    short_on = 0;
    repeat (5) @(negedge clk);
    chk(short_o == 1, "R6 short held while idle", short_o, 1);
  endtask

  task automatic t_clear;
    dev_on = 0; short_on = 0;
    run_cycle(-10);
    chk(short0 == 0 && pres0 == 0, "R6 both flags clear at new start", short0 + pres0, 0);
    chk(fin_short == 0, "R6 short gone after clean cycle", fin_short, 0);
  endtask

  task automatic t_overdrive;
    speed_i = 1; dev_on = 1; pw0 = 4; pw1 = 24;
    run_cycle(-10);
    chk(low_n == LO, "R2 od low length", low_n, LO);
    chk(busy_n == LO + HO, "R7 od busy length", busy_n, LO + HO);
    chk(pres_first == LO + MO + 1, "R5 od presence timing", pres_first, LO + MO + 1);
    speed_i = 0;
  endtask

  task automatic t_mask;
    mask_i = 1; dev_on = 1; pw0 = 15; pw1 = 240;
    run_cycle(-10);
    chk(fin_pres == 0 && pres_first < 0, "R8 masked presence stays 0", fin_pres, 0);
    mask_i = 0;
  endtask

  task automatic t_pullup;
    apu_i = 1; dev_on = 0;
    run_cycle(-10);
    chk(pu_n == PU, "R9 pullup length", pu_n, PU);
    chk(pu_first == LS, "R9 pullup start", pu_first, LS);
    chk(overlap == 0, "R9 pullup never with low", overlap, 0);
    apu_i = 0;
    @(negedge clk);
    chk(pullup_o == 0, "R9 pullup off while idle", pullup_o, 0);
  endtask

  task automatic t_restart;
    // std settings at start; mid-cycle strobe and flipped config must not matter
    speed_i = 0; mask_i = 0; apu_i = 0;
    dev_on = 1; pw0 = 15; pw1 = 240;
    run_cycle(100);
    chk(busy_n == LS + HS, "R10 busy length with mid-cycle strobe", busy_n, LS + HS);
    chk(low_n == LS, "R7 low length kept after speed change", low_n, LS);
    chk(pres_first == LS + MS + 1, "R7 mask change ignored mid-cycle", pres_first, LS + MS + 1);
    chk(pu_n == 0, "R7 apu change ignored mid-cycle", pu_n, 0);
    speed_i = 0; mask_i = 0; apu_i = 0;
    repeat (3) @(negedge clk);
    chk(busy_o == 0, "R10 no cycle launched by ignored strobe", busy_o, 0);
  endtask

  initial begin
    t_reset();
    t_std_present();
    t_std_absent();
    t_short();
    t_clear();
    t_overdrive();
    t_mask();
    t_pullup();
    t_restart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule